// File: doc/BRIEF.md
# Scalar-Vector Synchronization Request Controller

This block sits between a scalar core and an attached vector unit and handles the synchronization requests the scalar core issues. It handles three kinds of request:

- **Instruction sync** checks that no vector exception is still unreported.
- **Memory sync** performs the same check and then waits until all memory traffic has stopped.
- **Activity check** is privileged. It only waits for memory traffic to stop and ignores pending exceptions.

Exception dependency analysis is done outside the block. It arrives as two pre-computed summary flags: an arithmetic class, which leads to a vector-unit-disabled fault, and a memory-management class. Memory traffic arrives as one busy flag for each vector load/store path plus one busy flag from the scalar core.

The scalar core presents a request for one cycle while the controller is idle. The controller then holds the scalar core stalled until the request ends with either a one-cycle completion strobe or a one-cycle fault strobe. The completion strobe comes with a return word whose value carries no meaning and is driven to zero. The fault strobe comes with a fault code. After a fault the scalar core is expected to service it and reissue the same request.

Top module: `svsync_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `stall`, `done` and `fault` are low and `fault_code` is 00.
- R2: A request is accepted only when `req_valid` is high at a clock edge while the block is idle. From the next cycle, `stall` is high and stays high until the cycle in which `done` or `fault` is high; in that cycle `stall` is low.
- R3: The request kind is 2 bits: 00 instruction sync, 01 memory sync, 10 activity check, 11 reserved. For kinds 00 and 01, the exception flags are sampled once, one cycle after acceptance. If either flag is set, `fault` rises on the next cycle and no waiting occurs. Exceptions raised later are ignored.
- R4: Fault codes are 01 for vector-unit-disabled (arithmetic flag), 10 for memory management and 11 for an illegal kind. When both exception flags are set, the code is 01. `fault_code` is 00 whenever `fault` is low.
- R5: An instruction sync without pending exceptions asserts `done` two cycles after acceptance, whatever the busy flags are.
- R6: A memory sync without pending exceptions completes only once every vector path busy bit and the scalar busy flag are low at a clock edge. `done` goes high in the following cycle, and never earlier than three cycles after acceptance.
- R7: An activity check never faults, whatever the exception flags are. It completes under the same quiet-memory rule as R6.
- R8: A request of kind 11 faults with code 11 two cycles after acceptance.
- R9: `done` and `fault` each last exactly one cycle and are never high together. `ret_word` reads zero whenever `done` is high.
- R10: A `req_valid` that is high while a request is in progress has no effect on that request. It does not restart it, change its kind or alter its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request presented by the scalar core |
| req_kind | input | 2 | Request kind (00 instr sync, 01 mem sync, 10 activity check) |
| exc_arith | input | 1 | Unreported arithmetic exception pending |
| exc_mm | input | 1 | Unreported memory-management exception pending |
| vmem_busy | input | NUM_VPATHS | Busy flag of each vector load/store path |
| smem_busy | input | 1 | Scalar core memory operation in flight |
| stall | output | 1 | Hold the scalar core |
| done | output | 1 | One-cycle completion strobe |
| ret_word | output | RET_W | Return word, valid with `done` |
| fault | output | 1 | One-cycle fault strobe |
| fault_code | output | 2 | Fault class, valid with `fault` |

## Verification
The hardest situations to reach are those where the exception flags change relative to the single check cycle. One case is an exception that arrives while a memory sync is already waiting; it must not cause a fault. Another is a privileged activity check issued with both exception classes raised.

The stimulus holds the busy flags high for a chosen number of cycles and raises the exception flags only after the check cycle. It also keeps `req_valid` high through whole requests, which exercises back-to-back acceptance and R10.

// File: rtl/svsync_pkg.sv
package svsync_pkg;

   typedef enum logic [1:0] {
      KIND_ISYNC = 2'b00,
      KIND_MSYNC = 2'b01,
      KIND_ACT   = 2'b10,
      KIND_RSVD  = 2'b11
   } sync_kind_e;

   typedef enum logic [1:0] {
      FC_NONE = 2'b00,
      FC_DIS  = 2'b01,
      FC_MM   = 2'b10,
      FC_ILL  = 2'b11
   } fault_code_e;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_CHECK = 3'd1,
      ST_WAIT  = 3'd2,
      ST_DONE  = 3'd3,
      ST_FAULT = 3'd4
   } sync_state_e;

   typedef struct packed {
      logic needs_check;
      logic needs_quiet;
      logic illegal;
   } kind_attr_t;

endpackage

// File: rtl/svsync_kind_dec.sv
module svsync_kind_dec
   import svsync_pkg::*;
(
   input  sync_kind_e kind,
   output kind_attr_t attr
);
   always_comb begin
      attr = '0;
      unique case (kind)
         KIND_ISYNC: attr.needs_check = 1'b1;
         KIND_MSYNC: begin
            attr.needs_check = 1'b1;
            attr.needs_quiet = 1'b1;
         end
         KIND_ACT:   attr.needs_quiet = 1'b1;
         default:    attr.illegal     = 1'b1;
      endcase
   end
endmodule

// File: rtl/svsync_fault_pri.sv
module svsync_fault_pri
   import svsync_pkg::*;
(
   input  logic        illegal,
   input  logic        arith,
   input  logic        mm,
   output logic        any,
   output fault_code_e code
);
   always_comb begin
      if (illegal)    code = FC_ILL;
      else if (arith) code = FC_DIS;
      else if (mm)    code = FC_MM;
      else            code = FC_NONE;
      any = (code != FC_NONE);
   end

   // R4
   dis_over_mm_chk: assert final (!(arith && !illegal) || code == FC_DIS);
endmodule

// File: rtl/svsync_quiet.sv
module svsync_quiet #(
   parameter int NUM_VPATHS = 2
) (
   input  logic [NUM_VPATHS-1:0] vbusy,
   input  logic                  sbusy,
   output logic                  quiet
);
   logic [NUM_VPATHS:0] chain;

   assign chain[0] = sbusy;
   for (genvar p = 0; p < NUM_VPATHS; p++) begin : g_path
      assign chain[p+1] = chain[p] | vbusy[p];
   end
   assign quiet = ~chain[NUM_VPATHS];

   initial begin
      cfg_paths_chk: assert (NUM_VPATHS >= 1 && NUM_VPATHS <= 64)
         else $error("svsync_quiet: NUM_VPATHS out of range");
   end
endmodule

// File: rtl/svsync_ctrl.sv
module svsync_ctrl
   import svsync_pkg::*;
#(
   parameter int NUM_VPATHS = 2,
   parameter int RET_W      = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   input  logic [1:0]            req_kind,
   input  logic                  exc_arith,
   input  logic                  exc_mm,
   input  logic [NUM_VPATHS-1:0] vmem_busy,
   input  logic                  smem_busy,
   output logic                  stall,
   output logic                  done,
   output logic [RET_W-1:0]      ret_word,
   output logic                  fault,
   output logic [1:0]            fault_code
);
   sync_state_e st_q, st_d;
   sync_kind_e  kind_q;
   fault_code_e code_q;
   kind_attr_t  attr;
   logic        flt_any;
   fault_code_e flt_code;
   logic        quiet;

   initial begin
      cfg_ret_chk: assert (RET_W >= 1)
         else $error("svsync_ctrl: RET_W must be positive");
   end

   svsync_kind_dec u_dec (
      .kind (kind_q),
      .attr (attr)
   );

   svsync_fault_pri u_pri (
      .illegal (attr.illegal),
      .arith   (exc_arith & attr.needs_check),
      .mm      (exc_mm & attr.needs_check),
      .any     (flt_any),
      .code    (flt_code)
   );

   svsync_quiet #(.NUM_VPATHS(NUM_VPATHS)) u_quiet (
      .vbusy (vmem_busy),
      .sbusy (smem_busy),
      .quiet (quiet)
   );

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE:  if (req_valid) st_d = ST_CHECK;
         ST_CHECK: begin
            if (flt_any)               st_d = ST_FAULT;
            else if (attr.needs_quiet) st_d = ST_WAIT;
            else                       st_d = ST_DONE;
         end
         ST_WAIT:  if (quiet) st_d = ST_DONE;
         default:  st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         kind_q <= KIND_ISYNC;
         code_q <= FC_NONE;
      end else begin
         st_q <= st_d;
         if (st_q == ST_IDLE && req_valid) kind_q <= sync_kind_e'(req_kind);
         if (st_q == ST_CHECK)             code_q <= flt_code;
      end
   end

   assign stall      = (st_q == ST_CHECK) || (st_q == ST_WAIT);
   assign done       = (st_q == ST_DONE);
   assign fault      = (st_q == ST_FAULT);
   assign fault_code = fault ? code_q : FC_NONE;
   assign ret_word   = '0;

   // R2
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> (stall || done || fault));

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9
   fault_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> !fault);

   // R9
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && fault));

   // R7
   act_nofault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_CHECK && kind_q == KIND_ACT) |=> !fault);

   // R6
   quiet_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_WAIT && !quiet) |=> !done);

   // R4
   code_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fault |-> fault_code == 2'b00);
endmodule

// File: tb/tb_svsync_ctrl.sv
module tb_svsync_ctrl;
   localparam int NVP = 2;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           req_valid = 1'b0;
   logic [1:0]     req_kind = 2'b00;
   logic           exc_arith = 1'b0;
   logic           exc_mm = 1'b0;
   logic [NVP-1:0] vmem_busy = '0;
   logic           smem_busy = 1'b0;
   logic           stall, done, fault;
   logic [31:0]    ret_word;
   logic [1:0]     fault_code;

   int    tests = 0;
   int    fails = 0;
   string tag = "R1";

   // reference model: phase 0 idle, 1 check, 2 wait, 3 done, 4 fault
   int m_ph = 0;
   int m_kind = 0;
   int m_code = 0;

   svsync_ctrl #(.NUM_VPATHS(NVP), .RET_W(32)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .exc_arith(exc_arith), .exc_mm(exc_mm), .vmem_busy(vmem_busy),
      .smem_busy(smem_busy), .stall(stall), .done(done), .ret_word(ret_word),
      .fault(fault), .fault_code(fault_code)
   );

   always #10 clk = ~clk;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = 0;
         m_code = 0;
      end else begin
         case (m_ph)
            0: if (req_valid) begin m_kind = int'(req_kind); m_ph = 1; end
            1: begin
               if (m_kind == 3) begin m_ph = 4; m_code = 3; end
               else if (m_kind != 2 && exc_arith) begin m_ph = 4; m_code = 1; end
               else if (m_kind != 2 && exc_mm) begin m_ph = 4; m_code = 2; end
               else if (m_kind == 0) m_ph = 3;
               else m_ph = 2;
            end
            2: if (vmem_busy == '0 && !smem_busy) m_ph = 3;
            default: m_ph = 0;
         endcase
      end
   end

   task automatic chk(input string t, input string what, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", t, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         chk(tag, "stall", int'(stall), (m_ph == 1 || m_ph == 2) ? 1 : 0);
         chk(tag, "done", int'(done), (m_ph == 3) ? 1 : 0);
         chk(tag, "fault", int'(fault), (m_ph == 4) ? 1 : 0);
         chk(tag, "fault_code", int'(fault_code), (m_ph == 4) ? m_code : 0);
         if (done) chk(tag, "ret_word", int'(ret_word), 0);
      end
   end

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #2;
      end
   endtask

   // issue one request; exceptions held, busy released after hold cycles
   task automatic run(input string t, input logic [1:0] k, input logic ea, input logic em,
                      input logic [NVP-1:0] vb, input logic sb, input int hold);
      tag = t;
      req_kind = k; exc_arith = ea; exc_mm = em; vmem_busy = vb; smem_busy = sb;
      req_valid = 1'b1;
      step(1);
      req_valid = 1'b0;
      step(hold);
      vmem_busy = '0; smem_busy = 1'b0;
      step(4);
      exc_arith = 1'b0; exc_mm = 1'b0;
   endtask

   initial begin
      step(3);
      tag = "R1";
      chk("R1", "stall in reset", int'(stall), 0);
      chk("R1", "done in reset", int'(done), 0);
      chk("R1", "fault in reset", int'(fault), 0);
      chk("R1", "code in reset", int'(fault_code), 0);
      rst_n = 1'b1;
      step(2);

      run("R5", 2'b00, 0, 0, 2'b11, 1, 3);
      run("R3", 2'b00, 1, 0, 2'b00, 0, 0);
      run("R4", 2'b01, 0, 1, 2'b01, 1, 2);
      run("R4", 2'b01, 1, 1, 2'b00, 0, 0);
      run("R6", 2'b01, 0, 0, 2'b00, 0, 0);
      run("R6", 2'b01, 0, 0, 2'b10, 0, 5);
      run("R6", 2'b01, 0, 0, 2'b00, 1, 3);
      run("R7", 2'b10, 1, 1, 2'b01, 0, 4);
      run("R7", 2'b10, 0, 1, 2'b00, 0, 0);
      run("R8", 2'b11, 0, 0, 2'b11, 1, 0);
      run("R9", 2'b00, 0, 0, 2'b00, 0, 0);

      // R3: exception raised after the check cycle is ignored
      tag = "R3";
      req_kind = 2'b01; vmem_busy = 2'b01; req_valid = 1'b1;
      step(1);
      req_valid = 1'b0;
      step(2);
      exc_arith = 1'b1; exc_mm = 1'b1;
      step(3);
      vmem_busy = '0;
      step(4);
      exc_arith = 1'b0; exc_mm = 1'b0;

      // R10: req_valid held through a request with a changing kind
      tag = "R10";
      req_kind = 2'b01; smem_busy = 1'b1; req_valid = 1'b1;
      step(2);
      req_kind = 2'b11;
      step(3);
      req_kind = 2'b00;
      smem_busy = 1'b0;
      step(3);
      req_valid = 1'b0;
      step(5);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #2000000;
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule